// File: doc/BRIEF.md
# Status-Register NOR Flash Command Sequencer

This block turns a single host request into the series of bus cycles that a parallel NOR flash bank of the status-register style expects. The bank is two 16-bit devices side by side on a 32-bit word, so every command byte goes out in both halves and every status bit is judged in both halves. Three operations are supported: program one word, erase one block, and lock or unlock one block with a read-back of the lock state.

The host presents an operation code, a word address and a data word, and pulses start. The sequencer raises busy and drives one bus action per cycle: a write (write enable with address and data) or a read (read enable with address, read data taken in the same cycle). A program first reads the target word and refuses to start if any bit would have to go from 0 to 1. Program and erase then poll the ready bits until they are set, or until a parameterised cycle limit runs out and the operation is suspended. A lock or unlock reads back the protection bits and reports the state it finds. At the end, done pulses for one cycle with a result code and the lock flag.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, and whenever no operation is running, busy_o, done_o, fl_we_o and fl_re_o are all 0.
- R2: Operation code 0 (program) first reads the target address. If (read word AND write data) differs from the write data, done returns result 2 (not erased) and no bus write takes place. Bits that are already 0 where the new data is also 0 do not count as a conflict.
- R3: A program that passes the check writes 0x00500050, 0x00FF00FF, 0x00400040 and then the data word, all to the target address, each in its own cycle. Each command byte is copied into bits 7:0 and 23:16 with all other bits 0.
- R4: Polling reads the target address once per cycle. The operation is ready only when bit 7 and bit 23 of the read word are both 1. A word with only one of them set keeps the poll going.
- R5: If PROG_TMO polls of a program (or ERASE_TMO polls of an erase) all read not ready, the next cycle writes 0x00B000B0 to the address and the result is 1. Ready on exactly the last allowed poll counts as success.
- R6: After a program has been polled to completion or suspended, it writes 0x00500050 and then 0x00FF00FF. If the ready word had bit 4 or bit 20 set, the result is 1, otherwise 0.
- R7: Operation code 1 (erase) writes 0x00500050, 0x00200020 and 0x00D000D0 to the block address, polls as in R4 with the ERASE_TMO limit, and ends with one write of 0x00FF00FF. Bits 4 and 20 are not examined for an erase, and the result is 0 unless the poll timed out.
- R8: Operation codes 2 (lock) and 3 (unlock) write 0x00FF00FF, 0x00600060, then 0x00010001 for lock or 0x00D000D0 for unlock, then 0x00FF00FF and 0x00900090, all to the block address. They then read address+2 and finish with a write of 0x00FF00FF to the block address.
- R9: The read-back word is masked with 0x00010001. A masked value of 0 gives locked_o 0. A masked value of 0x00010001 gives locked_o 1. Any other masked value gives locked_o 1 and result 1. The result is also 1 whenever locked_o differs from the requested state. locked_o is 0 on done for program and erase.
- R10: busy_o rises in the cycle after an accepted start and stays high until done_o pulses for exactly one cycle, which is the last busy cycle. Every busy cycle before done carries exactly one bus read or one bus write.
- R11: A start pulse while busy is ignored. The running sequence, its result and its single done pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| op_i | input | 2 | 0 program, 1 erase, 2 lock, 3 unlock |
| addr_i | input | ADDR_W | Target word or block address |
| wdata_i | input | 32 | Word to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 failure or timeout, 2 not erased (valid with done) |
| locked_o | output | 1 | Lock state found by lock/unlock (valid with done) |
| fl_addr_o | output | ADDR_W | Flash word address |
| fl_wdata_o | output | 32 | Flash write data |
| fl_rdata_i | input | 32 | Flash read data, taken in the cycle of fl_re_o |
| fl_we_o | output | 1 | Flash write strobe |
| fl_re_o | output | 1 | Flash read strobe |

## Verification
Programs are run with a conflicting target word, a partially programmed but compatible word, one half ready before the other, an error bit in either half, a ready status on exactly the last allowed poll, and a status that never becomes ready. Together these separate the not-erased abort, the two-half ready test, the error check and the off-by-one edge of the timeout. Erases are run to completion with error bits set and to timeout, which shows that the erase tail differs from the program tail. Lock and unlock read-backs of clean, mixed, noisy-masked and contradicting values separate the three decoded states from the request mismatch, and start pulses during busy runs show that they have no effect.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int RDY_BIT = 7;
    localparam int ERR_BIT = 4;
    localparam int PROT_BIT = 0;

    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_ERASE  = 2'd1,
        OP_LOCK   = 2'd2,
        OP_UNLOCK = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RES_OK         = 2'd0,
        RES_FAIL       = 2'd1,
        RES_NOT_ERASED = 2'd2
    } res_e;

    typedef enum logic [1:0] {
        LK_OPEN  = 2'd0,
        LK_SHUT  = 2'd1,
        LK_MIXED = 2'd2
    } lk_e;

    typedef struct packed {
        logic ready;
        logic err;
        lk_e  lk;
        logic covers;
    } stat_t;

    typedef enum logic [4:0] {
        S_IDLE, S_PRECHK, S_CLR, S_RDM, S_PSET, S_PDATA,
        S_ESET, S_ECONF, S_POLL, S_SUSP, S_TCLR, S_TRDM,
        S_LRDM, S_LSET, S_LACT, S_LRDM2, S_LID, S_LREAD,
        S_LEXIT, S_FIN
    } st_e;

    localparam logic [7:0] C_CLEAR   = 8'h50;
    localparam logic [7:0] C_ARRAY   = 8'hFF;
    localparam logic [7:0] C_PSETUP  = 8'h40;
    localparam logic [7:0] C_ESETUP  = 8'h20;
    localparam logic [7:0] C_CONFIRM = 8'hD0;
    localparam logic [7:0] C_SUSPEND = 8'hB0;
    localparam logic [7:0] C_LSETUP  = 8'h60;
    localparam logic [7:0] C_SETLOCK = 8'h01;
    localparam logic [7:0] C_IDREAD  = 8'h90;

    function automatic logic [WORD_W-1:0] both_halves(input logic [7:0] c);
        return {{(HALF_W-8){1'b0}}, c, {(HALF_W-8){1'b0}}, c};
    endfunction

endpackage

// File: rtl/nsq_status_eval.sv
module nsq_status_eval
    import nor_seq_pkg::*;
(
    input  logic [WORD_W-1:0] rdata_i,
    input  logic [WORD_W-1:0] want_i,
    output stat_t             st_o
);
    logic [1:0] rdy_h;
    logic [1:0] err_h;
    logic [1:0] prot_h;

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign rdy_h[h]  = rdata_i[h*HALF_W + RDY_BIT];
        assign err_h[h]  = rdata_i[h*HALF_W + ERR_BIT];
        assign prot_h[h] = rdata_i[h*HALF_W + PROT_BIT];
    end

    always_comb begin
        st_o.ready  = &rdy_h;
        st_o.err    = |err_h;
        st_o.covers = ((rdata_i & want_i) == want_i);
        case (prot_h)
            2'b00:   st_o.lk = LK_OPEN;
            2'b11:   st_o.lk = LK_SHUT;
            default: st_o.lk = LK_MIXED;
        endcase
    end
endmodule

// File: rtl/nsq_poll_timer.sv
module nsq_poll_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) cnt_q <= '0;
        else if (step_i)    cnt_q <= cnt_q + CNT_W'(1);
    end

    assign last_o = (cnt_q == limit_i - CNT_W'(1));

    AST_POLL_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        step_i |-> (cnt_q < limit_i)) else $error("poll count past limit"); // R5
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int PROG_TMO  = 16,
    parameter int ERASE_TMO = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        result_o,
    output logic              locked_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [31:0]       fl_wdata_o,
    input  logic [31:0]       fl_rdata_i,
    output logic              fl_we_o,
    output logic              fl_re_o
);
    localparam int TMO_MAX = (PROG_TMO > ERASE_TMO) ? PROG_TMO : ERASE_TMO;
    localparam int CNT_W   = $clog2(TMO_MAX + 1);

    st_e               state_q, state_d;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    res_e              res_q, res_d;
    logic              lock_q, lock_d;

    stat_t             st;
    logic              poll_last;
    logic [CNT_W-1:0]  poll_limit;
    logic              is_prog;
    logic              want_lock;

    assign is_prog    = (op_q == OP_PROG);
    assign want_lock  = (op_q == OP_LOCK);
    assign poll_limit = (op_q == OP_ERASE) ? CNT_W'(ERASE_TMO) : CNT_W'(PROG_TMO);

    nsq_status_eval u_eval (
        .rdata_i (fl_rdata_i),
        .want_i  (data_q),
        .st_o    (st)
    );

    nsq_poll_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear_i (state_q != S_POLL),
        .step_i  (state_q == S_POLL),
        .limit_i (poll_limit),
        .last_o  (poll_last)
    );

    // Bus action driven by the current step
    always_comb begin
        fl_we_o    = 1'b0;
        fl_re_o    = 1'b0;
        fl_addr_o  = addr_q;
        fl_wdata_o = '0;
        case (state_q)
            S_PRECHK, S_POLL: fl_re_o = 1'b1;
            S_LREAD: begin
                fl_re_o   = 1'b1;
                fl_addr_o = addr_q + ADDR_W'(2);
            end
            S_CLR, S_TCLR: begin
                fl_we_o = 1'b1; fl_wdata_o = both_halves(C_CLEAR);
            end
            S_RDM, S_TRDM, S_LRDM, S_LRDM2, S_LEXIT: begin
                fl_we_o = 1'b1; fl_wdata_o = both_halves(C_ARRAY);
            end
            S_PSET:  begin fl_we_o = 1'b1; fl_wdata_o = both_halves(C_PSETUP);  end
            S_PDATA: begin fl_we_o = 1'b1; fl_wdata_o = data_q;                 end
            S_ESET:  begin fl_we_o = 1'b1; fl_wdata_o = both_halves(C_ESETUP);  end
            S_ECONF: begin fl_we_o = 1'b1; fl_wdata_o = both_halves(C_CONFIRM); end
            S_SUSP:  begin fl_we_o = 1'b1; fl_wdata_o = both_halves(C_SUSPEND); end
            S_LSET:  begin fl_we_o = 1'b1; fl_wdata_o = both_halves(C_LSETUP);  end
            S_LACT: begin
                fl_we_o    = 1'b1;
                fl_wdata_o = want_lock ? both_halves(C_SETLOCK) : both_halves(C_CONFIRM);
            end
            S_LID:   begin fl_we_o = 1'b1; fl_wdata_o = both_halves(C_IDREAD);  end
            default: ;
        endcase
    end

    // Step ordering and outcome
    always_comb begin
        state_d = state_q;
        res_d   = res_q;
        lock_d  = lock_q;
        case (state_q)
            S_IDLE: if (start_i) begin
                res_d  = RES_OK;
                lock_d = 1'b0;
                case (op_e'(op_i))
                    OP_PROG:  state_d = S_PRECHK;
                    OP_ERASE: state_d = S_CLR;
                    default:  state_d = S_LRDM;
                endcase
            end
            S_PRECHK: begin
                if (st.covers) state_d = S_CLR;
                else begin
                    res_d   = RES_NOT_ERASED;
                    state_d = S_FIN;
                end
            end
            S_CLR:   state_d = is_prog ? S_RDM : S_ESET;
            S_RDM:   state_d = S_PSET;
            S_PSET:  state_d = S_PDATA;
            S_PDATA: state_d = S_POLL;
            S_ESET:  state_d = S_ECONF;
            S_ECONF: state_d = S_POLL;
            S_POLL: begin
                if (st.ready) begin
                    res_d   = (is_prog && st.err) ? RES_FAIL : RES_OK;
                    state_d = is_prog ? S_TCLR : S_TRDM;
                end else if (poll_last) begin
                    res_d   = RES_FAIL;
                    state_d = S_SUSP;
                end
            end
            S_SUSP:  state_d = is_prog ? S_TCLR : S_TRDM;
            S_TCLR:  state_d = S_TRDM;
            S_TRDM:  state_d = S_FIN;
            S_LRDM:  state_d = S_LSET;
            S_LSET:  state_d = S_LACT;
            S_LACT:  state_d = S_LRDM2;
            S_LRDM2: state_d = S_LID;
            S_LID:   state_d = S_LREAD;
            S_LREAD: begin
                lock_d = (st.lk != LK_OPEN);
                res_d  = ((st.lk == LK_MIXED) || ((st.lk == LK_SHUT) != want_lock))
                         ? RES_FAIL : RES_OK;
                state_d = S_LEXIT;
            end
            S_LEXIT: state_d = S_FIN;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            op_q    <= OP_PROG;
            addr_q  <= '0;
            data_q  <= '0;
            res_q   <= RES_OK;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            res_q   <= res_d;
            lock_q  <= lock_d;
            if (state_q == S_IDLE && start_i) begin
                op_q   <= op_e'(op_i);
                addr_q <= addr_i;
                data_q <= wdata_i;
            end
        end
    end

    assign busy_o   = (state_q != S_IDLE);
    assign done_o   = (state_q == S_FIN);
    assign result_o = done_o ? res_q : 2'd0;
    assign locked_o = done_o & lock_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!fl_we_o && !fl_re_o && !done_o)) else $error("activity while idle"); // R1
    AST_NOT_ERASED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (done_o && result_o == 2'd2) |-> ($past(fl_re_o) && !$past(fl_we_o))) else $error("write before abort"); // R2
    AST_CMD_BOTH_HALVES: assert property (@(posedge clk) disable iff (rst)
        (fl_we_o && state_q != S_PDATA) |-> (fl_wdata_o[31:16] == fl_wdata_o[15:0])) else $error("command halves differ"); // R3
    AST_ONE_BUS_ACTION: assert property (@(posedge clk) disable iff (rst)
        !(fl_we_o && fl_re_o)) else $error("read and write together"); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o)) else $error("done not a single pulse"); // R10
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o) else $error("busy dropped early"); // R11
    AST_LOCK_FLAG_SCOPE: assert property (@(posedge clk) disable iff (rst)
        (done_o && locked_o) |-> (op_q == OP_LOCK || op_q == OP_UNLOCK)) else $error("lock flag on non-lock op"); // R9
endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb_top;
    localparam int AW = 24;
    localparam int PT = 16;
    localparam int ET = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    op = 2'd0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          busy, done, locked, we, re;
    logic [1:0]    result;
    logic [AW-1:0] faddr;
    logic [31:0]   fwdata, frdata;

    always #2.5 clk = ~clk;

    nor_cmd_seq #(.ADDR_W(AW), .PROG_TMO(PT), .ERASE_TMO(ET)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .op_i(op), .addr_i(addr),
        .wdata_i(wdata), .busy_o(busy), .done_o(done), .result_o(result),
        .locked_o(locked), .fl_addr_o(faddr), .fl_wdata_o(fwdata),
        .fl_rdata_i(frdata), .fl_we_o(we), .fl_re_o(re)
    );

    // Flash model: one response word per read, in order
    logic [31:0] resp [0:63];
    logic [6:0]  rptr;
    logic        rp_clr = 1'b1;
    assign frdata = resp[rptr[5:0]];
    always @(posedge clk) begin
        if (rp_clr)  rptr <= '0;
        else if (re) rptr <= rptr + 7'd1;
    end

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] a;
        logic [31:0]   d;
    } txn_t;
    txn_t expq[$];

    int    checks = 0;
    int    errors = 0;
    int    done_cnt = 0;
    string req = "R1";
    logic [1:0] exp_res = 2'd0;
    logic       exp_lk  = 1'b0;
    bit         mon_on  = 1'b0;

    function automatic logic [31:0] rc(input logic [7:0] c);
        return {8'h00, c, 8'h00, c};
    endfunction

    function automatic void ew(input logic [AW-1:0] a, input logic [31:0] d);
        txn_t t; t.wr = 1'b1; t.a = a; t.d = d; expq.push_back(t);
    endfunction

    function automatic void er(input logic [AW-1:0] a);
        txn_t t; t.wr = 1'b0; t.a = a; t.d = '0; expq.push_back(t);
    endfunction

    function automatic void chk(input bit ok, input string r, input string what,
                                input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endfunction

    function automatic void fill(input logic [31:0] v);
        for (int i = 0; i < 64; i++) resp[i] = v;
    endfunction

    // Cycle-by-cycle comparison against the expected bus queue
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (done) begin
                done_cnt++;
                chk(result == exp_res, req, "result", 64'(result), 64'(exp_res));
                chk(locked == exp_lk, "R9", "locked flag", 64'(locked), 64'(exp_lk));
                chk(expq.size() == 0, req, "bus actions left", 64'(expq.size()), 64'd0);
                chk(busy == 1'b1, "R10", "busy with done", 64'(busy), 64'd1);
            end else if (busy) begin
                if (we == re) begin
                    chk(1'b0, "R10", "one bus action per busy cycle", {62'd0, we, re}, 64'd1);
                end else if (expq.size() == 0) begin
                    chk(1'b0, req, "unexpected bus action", 64'(faddr), 64'd0);
                end else begin
                    txn_t t;
                    t = expq.pop_front();
                    chk(we == t.wr, req, "bus direction", 64'(we), 64'(t.wr));
                    chk(faddr == t.a, req, "bus address", 64'(faddr), 64'(t.a));
                    if (t.wr) chk(fwdata == t.d, req, "write data", 64'(fwdata), 64'(t.d));
                end
            end else begin
                if (we || re) chk(1'b0, "R1", "bus action while idle", {62'd0, we, re}, 64'd0);
            end
        end
    end

    task automatic run_op(input string r, input logic [1:0] o, input logic [AW-1:0] a,
                          input logic [31:0] d, input logic [1:0] xres,
                          input logic xlk, input bit poke);
        int w;
        req = r; exp_res = xres; exp_lk = xlk; done_cnt = 0;
        @(negedge clk); rp_clr = 1'b1;
        @(negedge clk); rp_clr = 1'b0;
        op = o; addr = a; wdata = d; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            op = ~o; addr = a + AW'(7); wdata = ~d; start = 1'b1;   // R11
            @(negedge clk); start = 1'b0;
        end
        w = 0;
        while (done_cnt == 0 && w < 500) begin
            @(negedge clk); w++;
        end
        chk(done_cnt != 0, r, "done seen", 64'(done_cnt), 64'd1);
        @(negedge clk);
        chk(busy == 1'b0, "R10", "idle after done", 64'(busy), 64'd0);
        chk(done_cnt == 1, "R11", "single done", 64'(done_cnt), 64'd1);
        expq.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [AW-1:0] A = 24'h012340;
    localparam logic [AW-1:0] B = 24'h3F0000;

    initial begin
        fill(32'h0);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !we && !re, "R1", "outputs in reset",
            {60'd0, busy, done, we, re}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !we && !re, "R1", "outputs after reset",
            {60'd0, busy, done, we, re}, 64'd0);
        mon_on = 1'b1;

        // R2: conflicting target word, no writes
        fill(32'h0); resp[0] = 32'h0000FFFF;
        er(A);
        run_op("R2", 2'd0, A, 32'h00010000, 2'd2, 1'b0, 1'b0);

        // R3 R4: full program, upper half ready first; start poked while busy (R11)
        fill(32'h0); resp[0] = 32'hFFFFFFFF; resp[2] = 32'h00800000; resp[3] = 32'h00800080;
        er(A); ew(A, rc(8'h50)); ew(A, rc(8'hFF)); ew(A, rc(8'h40)); ew(A, 32'h12345678);
        er(A); er(A); er(A); ew(A, rc(8'h50)); ew(A, rc(8'hFF));
        run_op("R3", 2'd0, A, 32'h12345678, 2'd0, 1'b0, 1'b1);

        // R6: error bit in lower half
        fill(32'h0); resp[0] = 32'hFFFFFFFF; resp[1] = 32'h00800090;
        er(A); ew(A, rc(8'h50)); ew(A, rc(8'hFF)); ew(A, rc(8'h40)); ew(A, 32'h0000AAAA);
        er(A); ew(A, rc(8'h50)); ew(A, rc(8'hFF));
        run_op("R6", 2'd0, A, 32'h0000AAAA, 2'd1, 1'b0, 1'b0);

        // R6: error bit in upper half
        fill(32'h0); resp[0] = 32'hFFFFFFFF; resp[1] = 32'h00900080;
        er(B); ew(B, rc(8'h50)); ew(B, rc(8'hFF)); ew(B, rc(8'h40)); ew(B, 32'h55550000);
        er(B); ew(B, rc(8'h50)); ew(B, rc(8'hFF));
        run_op("R6", 2'd0, B, 32'h55550000, 2'd1, 1'b0, 1'b0);

        // R5 with R2 boundary: compatible partial word, never ready (lower half only)
        fill(32'h00000080); resp[0] = 32'h0F0F0F0F;
        er(A); ew(A, rc(8'h50)); ew(A, rc(8'hFF)); ew(A, rc(8'h40)); ew(A, 32'h05050505);
        for (int i = 0; i < PT; i++) er(A);
        ew(A, rc(8'hB0)); ew(A, rc(8'h50)); ew(A, rc(8'hFF));
        run_op("R5", 2'd0, A, 32'h05050505, 2'd1, 1'b0, 1'b0);

        // R5: ready on the last allowed poll
        fill(32'h0); resp[0] = 32'hFFFFFFFF; resp[PT] = 32'h00800080;
        er(A); ew(A, rc(8'h50)); ew(A, rc(8'hFF)); ew(A, rc(8'h40)); ew(A, 32'hCAFEF00D);
        for (int i = 0; i < PT; i++) er(A);
        ew(A, rc(8'h50)); ew(A, rc(8'hFF));
        run_op("R5", 2'd0, A, 32'hCAFEF00D, 2'd0, 1'b0, 1'b0);

        // R7: erase, ready word with error bits that erase ignores; poked while busy
        fill(32'h0); resp[4] = 32'hFFFFFFFF;
        ew(B, rc(8'h50)); ew(B, rc(8'h20)); ew(B, rc(8'hD0));
        for (int i = 0; i < 5; i++) er(B);
        ew(B, rc(8'hFF));
        run_op("R7", 2'd1, B, 32'h0, 2'd0, 1'b0, 1'b1);

        // R7 with R5: erase timeout uses the longer limit
        fill(32'h0);
        ew(B, rc(8'h50)); ew(B, rc(8'h20)); ew(B, rc(8'hD0));
        for (int i = 0; i < ET; i++) er(B);
        ew(B, rc(8'hB0)); ew(B, rc(8'hFF));
        run_op("R7", 2'd1, B, 32'h0, 2'd1, 1'b0, 1'b0);

        // R8 R9: lock, read back locked
        fill(32'h0); resp[0] = 32'h00010001;
        ew(B, rc(8'hFF)); ew(B, rc(8'h60)); ew(B, rc(8'h01)); ew(B, rc(8'hFF)); ew(B, rc(8'h90));
        er(B + AW'(2)); ew(B, rc(8'hFF));
        run_op("R8", 2'd2, B, 32'h0, 2'd0, 1'b1, 1'b1);

        // R8 R9: unlock, read back clear once masked
        fill(32'h0); resp[0] = 32'h00FE00FE;
        ew(A, rc(8'hFF)); ew(A, rc(8'h60)); ew(A, rc(8'hD0)); ew(A, rc(8'hFF)); ew(A, rc(8'h90));
        er(A + AW'(2)); ew(A, rc(8'hFF));
        run_op("R8", 2'd3, A, 32'h0, 2'd0, 1'b0, 1'b0);

        // R9: mixed state reported as locked with failure
        fill(32'h0); resp[0] = 32'h00000001;
        ew(B, rc(8'hFF)); ew(B, rc(8'h60)); ew(B, rc(8'h01)); ew(B, rc(8'hFF)); ew(B, rc(8'h90));
        er(B + AW'(2)); ew(B, rc(8'hFF));
        run_op("R9", 2'd2, B, 32'h0, 2'd1, 1'b1, 1'b0);

        // R9: unlock requested but still locked
        fill(32'h0); resp[0] = 32'h00FF00FF;
        ew(A, rc(8'hFF)); ew(A, rc(8'h60)); ew(A, rc(8'hD0)); ew(A, rc(8'hFF)); ew(A, rc(8'h90));
        er(A + AW'(2)); ew(A, rc(8'hFF));
        run_op("R9", 2'd3, A, 32'h0, 2'd1, 1'b1, 1'b0);

        // R9: lock requested but reads open
        fill(32'h0); resp[0] = 32'hFFFEFFFE;
        ew(A, rc(8'hFF)); ew(A, rc(8'h60)); ew(A, rc(8'h01)); ew(A, rc(8'hFF)); ew(A, rc(8'h90));
        er(A + AW'(2)); ew(A, rc(8'hFF));
        run_op("R9", 2'd2, A, 32'h0, 2'd1, 1'b0, 1'b0);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule